// File: doc/BRIEF.md
# PHY Power-Up Reset Sequencer

This block takes a serial-link PHY and its controller from the held-in-reset condition to an operational state. It runs a fixed, timed series of steps. A one-cycle start pulse launches the series. The three gated clocks (PHY, bus, core) are switched on one cycle apart. The PHY test-powerdown is then lifted and the reference clock enabled. The clocks are given time to settle. An optional endpoint reset line is held and then released. A variant-dependent reset release follows. The ready output is raised at the end.

Three silicon variants are supported through a two-bit select that is captured at start. They differ in two places. The first is whether a gap is placed between lifting powerdown and enabling the reference clock. The second is which internal reset, if any, is released at the end. A shutdown input puts every output back to its reset value on the next cycle, from any state. All delays are parameters in clock cycles.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After rst_ni and while idle: test-powerdown = 1, reference-clock enable = 0, all three clock enables = 0, endpoint reset at its active level, core soft reset = 1, PHY button reset = 1, ready = 0.
- R2: With start_i sampled high at clock edge 0, the PHY clock enable rises after edge 0, the bus clock enable after edge 1, and the core clock enable after edge 2. Each enable stays high until shutdown.
- R3: For variant 0 (basic) and 1 (soft-reset), test-powerdown falls after edge 3. The reference-clock enable rises REFGAP_CYC cycles later.
- R4: For variant 2 (button-reset), test-powerdown falls and the reference-clock enable rises together after edge 3, with no gap. Variant code 3 behaves as variant 0.
- R5: The reference clock settles for SETTLE_CYC cycles. If ext_rst_en_i was high at start, the endpoint reset then stays active for EPRST_CYC further cycles before release. The active level equals ep_rst_pol_i (1 = active high), and the released level is its inverse.
- R6: If ext_rst_en_i was low at start, the endpoint-reset hold is skipped, and the release step follows the settle time directly.
- R7: At the release step, variant 1 clears the core soft reset and waits SOFTWAIT_CYC cycles, and variant 2 clears the PHY button reset. Variant 0 clears neither, and both stay at 1.
- R8: ready_o rises one cycle after the last step (SOFTWAIT_CYC cycles after it for variant 1) and stays high, with all enables on, until shutdown.
- R9: shutdown_i sampled high at an edge returns every output to the R1 values after that edge, from any state. start_i has no effect while shutdown_i is high.
- R10: Once a sequence has started, further start pulses and changes of variant_i or ext_rst_en_i do not alter its timing or its outcome, including after ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, acted on when idle |
| variant_i | input | 2 | 0 basic, 1 soft-reset, 2 button-reset, 3 as basic |
| ext_rst_en_i | input | 1 | Endpoint reset line fitted |
| ep_rst_pol_i | input | 1 | Endpoint reset active level (1 = high) |
| shutdown_i | input | 1 | Return to reset state |
| phy_test_pd_o | output | 1 | PHY test-powerdown |
| ref_clk_en_o | output | 1 | Reference clock enable |
| phy_clk_en_o | output | 1 | PHY clock gate enable |
| bus_clk_en_o | output | 1 | Bus clock gate enable |
| core_clk_en_o | output | 1 | Core clock gate enable |
| ep_rst_o | output | 1 | Endpoint reset line |
| core_soft_rst_o | output | 1 | Core soft reset |
| phy_btn_rst_o | output | 1 | PHY button reset |
| ready_o | output | 1 | Sequence complete |

## Verification
The sequence is run once for each variant, and the cycle at which every output first changes is compared with values computed from the delay parameters. This separates the gapped variants from the gapless one, and shows which reset each variant releases. Runs with the endpoint line present or absent, and with both polarities, separate the hold timing from the skip path and check the level of the line. Shutdown is applied mid-settle and after ready, with a start pulse held against it. A stray start pulse and a variant change are injected during a run and after ready, to show that a sequence under way cannot be disturbed.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_PHY   = 4'd1,
    ST_BUS   = 4'd2,
    ST_CORE  = 4'd3,
    ST_PDOFF = 4'd4,
    ST_REF   = 4'd5,
    ST_EPRST = 4'd6,
    ST_REL   = 4'd7,
    ST_DONE  = 4'd8
  } seq_state_e;

  typedef enum logic [1:0] {
    VAR_BASIC = 2'd0,
    VAR_SOFT  = 2'd1,
    VAR_BTN   = 2'd2,
    VAR_ALT   = 2'd3
  } seq_var_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [CW-1:0] lim_i,
  output logic          exp_o
);
  logic [CW-1:0] cnt_q;

  assign exp_o = (cnt_q == lim_i - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (run_i && !exp_o) cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < lim_i)) else $error("count past limit"); // R5
endmodule

// File: rtl/phy_seq_fsm.sv
module phy_seq_fsm
  import phy_seq_pkg::*;
#(
  parameter int REFGAP_CYC   = 500,
  parameter int SETTLE_CYC   = 10000,
  parameter int EPRST_CYC    = 5000000,
  parameter int SOFTWAIT_CYC = 10000,
  parameter int CW           = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] variant_i,
  input  logic       ext_rst_en_i,
  input  logic       shutdown_i,
  output seq_state_e state_o,
  output seq_var_e   var_o
);
  seq_state_e state_q, state_d;
  seq_var_e   var_q;
  logic       ext_q;
  logic       tmr_clr, tmr_run, tmr_exp;
  logic [CW-1:0] tmr_lim;

  always_comb begin
    unique case (state_q)
      ST_PDOFF: tmr_lim = CW'(REFGAP_CYC);
      ST_REF:   tmr_lim = CW'(SETTLE_CYC);
      ST_EPRST: tmr_lim = CW'(EPRST_CYC);
      ST_REL:   tmr_lim = (var_q == VAR_SOFT) ? CW'(SOFTWAIT_CYC) : CW'(1);
      default:  tmr_lim = CW'(1);
    endcase
  end

  assign tmr_run = (state_q == ST_PDOFF) || (state_q == ST_REF) ||
                   (state_q == ST_EPRST) || (state_q == ST_REL);
  assign tmr_clr = (state_d != state_q);

  phy_seq_timer #(.CW(CW)) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .run_i (tmr_run),
    .lim_i (tmr_lim),
    .exp_o (tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_PHY;
      ST_PHY:   state_d = ST_BUS;
      ST_BUS:   state_d = ST_CORE;
      ST_CORE:  state_d = (var_q == VAR_BTN) ? ST_REF : ST_PDOFF;
      ST_PDOFF: if (tmr_exp) state_d = ST_REF;
      ST_REF:   if (tmr_exp) state_d = ext_q ? ST_EPRST : ST_REL;
      ST_EPRST: if (tmr_exp) state_d = ST_REL;
      ST_REL:   if (tmr_exp) state_d = ST_DONE;
      ST_DONE:  state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
    if (shutdown_i) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      var_q   <= VAR_BASIC;
      ext_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i && !shutdown_i) begin
        var_q <= seq_var_e'(variant_i);
        ext_q <= ext_rst_en_i;
      end
    end
  end

  assign state_o = state_q;
  assign var_o   = var_q;

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !shutdown_i) |=> $stable(var_q)) else $error("variant changed mid-run"); // R10
  AST_SKIP_EPRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REF && !ext_q) |-> (state_d != ST_EPRST)) else $error("hold not skipped"); // R6
endmodule

// File: rtl/phy_seq_outs.sv
module phy_seq_outs
  import phy_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e state_i,
  input  seq_var_e   var_i,
  input  logic       pol_i,
  output logic       phy_test_pd_o,
  output logic       ref_clk_en_o,
  output logic       phy_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       core_clk_en_o,
  output logic       ep_rst_o,
  output logic       core_soft_rst_o,
  output logic       phy_btn_rst_o,
  output logic       ready_o
);
  logic ep_act, rel_step;

  assign rel_step        = (state_i >= ST_REL);
  assign phy_clk_en_o    = (state_i >= ST_PHY);
  assign bus_clk_en_o    = (state_i >= ST_BUS);
  assign core_clk_en_o   = (state_i >= ST_CORE);
  assign phy_test_pd_o   = (state_i <  ST_PDOFF);
  assign ref_clk_en_o    = (state_i >= ST_REF);
  assign ep_act          = !rel_step;
  assign ep_rst_o        = ep_act ? pol_i : !pol_i;
  assign core_soft_rst_o = !(rel_step && var_i == VAR_SOFT);
  assign phy_btn_rst_o   = !(rel_step && var_i == VAR_BTN);
  assign ready_o         = (state_i == ST_DONE);

  AST_CLK_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_clk_en_o |-> bus_clk_en_o) and (bus_clk_en_o |-> phy_clk_en_o)) else $error("clock order"); // R2
  AST_REF_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_clk_en_o) && var_i != VAR_BTN) |-> $past(!phy_test_pd_o)) else $error("no gap"); // R3
  AST_REF_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clk_en_o |-> !phy_test_pd_o) else $error("ref before pd lift"); // R4
  AST_EP_AFTER_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep_rst_o != pol_i) |-> (ref_clk_en_o && core_clk_en_o)) else $error("early ep release"); // R5
  AST_READY_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ref_clk_en_o && core_clk_en_o && !phy_test_pd_o)) else $error("ready early"); // R8
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import phy_seq_pkg::*;
#(
  parameter int REFGAP_CYC   = 500,
  parameter int SETTLE_CYC   = 10000,
  parameter int EPRST_CYC    = 5000000,
  parameter int SOFTWAIT_CYC = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] variant_i,
  input  logic       ext_rst_en_i,
  input  logic       ep_rst_pol_i,
  input  logic       shutdown_i,
  output logic       phy_test_pd_o,
  output logic       ref_clk_en_o,
  output logic       phy_clk_en_o,
  output logic       bus_clk_en_o,
  output logic       core_clk_en_o,
  output logic       ep_rst_o,
  output logic       core_soft_rst_o,
  output logic       phy_btn_rst_o,
  output logic       ready_o
);
  localparam int MAX_CYC = max2(max2(REFGAP_CYC, SETTLE_CYC), max2(EPRST_CYC, SOFTWAIT_CYC));
  localparam int CW      = $clog2(MAX_CYC + 1) + 1;

  seq_state_e state;
  seq_var_e   var_sel;

  phy_seq_fsm #(
    .REFGAP_CYC  (REFGAP_CYC),
    .SETTLE_CYC  (SETTLE_CYC),
    .EPRST_CYC   (EPRST_CYC),
    .SOFTWAIT_CYC(SOFTWAIT_CYC),
    .CW          (CW)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .variant_i   (variant_i),
    .ext_rst_en_i(ext_rst_en_i),
    .shutdown_i  (shutdown_i),
    .state_o     (state),
    .var_o       (var_sel)
  );

  phy_seq_outs i_outs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .state_i        (state),
    .var_i          (var_sel),
    .pol_i          (ep_rst_pol_i),
    .phy_test_pd_o  (phy_test_pd_o),
    .ref_clk_en_o   (ref_clk_en_o),
    .phy_clk_en_o   (phy_clk_en_o),
    .bus_clk_en_o   (bus_clk_en_o),
    .core_clk_en_o  (core_clk_en_o),
    .ep_rst_o       (ep_rst_o),
    .core_soft_rst_o(core_soft_rst_o),
    .phy_btn_rst_o  (phy_btn_rst_o),
    .ready_o        (ready_o)
  );

  AST_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> (phy_test_pd_o && !ref_clk_en_o && !phy_clk_en_o && !bus_clk_en_o &&
                    !core_clk_en_o && core_soft_rst_o && phy_btn_rst_o && !ready_o &&
                    (ep_rst_o == ep_rst_pol_i))) else $error("shutdown"); // R9
endmodule

// File: tb/test_phy_pwrup_seq.sv
module test_phy_pwrup_seq;
  localparam int G = 3, S = 4, E = 5, W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ext_en = 1'b1, pol = 1'b1, shut = 1'b0;
  logic [1:0] var_sel = 2'd0;
  logic pd, refc, phyc, busc, corec, ep, softr, btnr, rdy;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  phy_pwrup_seq #(.REFGAP_CYC(G), .SETTLE_CYC(S), .EPRST_CYC(E), .SOFTWAIT_CYC(W)) i_phy_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .variant_i(var_sel),
    .ext_rst_en_i(ext_en), .ep_rst_pol_i(pol), .shutdown_i(shut),
    .phy_test_pd_o(pd), .ref_clk_en_o(refc), .phy_clk_en_o(phyc), .bus_clk_en_o(busc),
    .core_clk_en_o(corec), .ep_rst_o(ep), .core_soft_rst_o(softr), .phy_btn_rst_o(btnr),
    .ready_o(rdy));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_reset_state(input string req);
    chk({req, " pd"}, pd, 1);     chk({req, " ref"}, refc, 0);
    chk({req, " phyclk"}, phyc, 0); chk({req, " busclk"}, busc, 0);
    chk({req, " coreclk"}, corec, 0); chk({req, " ep"}, ep, pol);
    chk({req, " soft"}, softr, 1); chk({req, " btn"}, btnr, 1);
    chk({req, " ready"}, rdy, 0);
  endtask

  // Runs a sequence and checks the cycle each output first changes.
  task automatic run_seq(input logic [1:0] v, input logic en, input logic p, input bit disturb);
    int t_phy = 0, t_bus = 0, t_core = 0, t_pd = 0, t_ref = 0, t_ep = 0;
    int t_soft = 0, t_btn = 0, t_rdy = 0;
    int e_ref, e_rel, e_rdy;
    @(negedge clk);
    var_sel = v; ext_en = en; pol = p; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 40; n++) begin
      if (phyc  && t_phy  == 0) t_phy  = n;
      if (busc  && t_bus  == 0) t_bus  = n;
      if (corec && t_core == 0) t_core = n;
      if (!pd   && t_pd   == 0) t_pd   = n;
      if (refc  && t_ref  == 0) t_ref  = n;
      if (ep != p && t_ep == 0) t_ep   = n;
      if (!softr && t_soft == 0) t_soft = n;
      if (!btnr && t_btn  == 0) t_btn  = n;
      if (rdy   && t_rdy  == 0) t_rdy  = n;
      if (disturb && n == 2) begin start = 1'b1; var_sel = v ^ 2'd3; ext_en = !en; end
      if (disturb && n == 3) start = 1'b0;
      @(negedge clk);
    end
    e_ref = (v == 2'd2) ? 4 : 4 + G;
    e_rel = e_ref + S + (en ? E : 0);
    e_rdy = e_rel + ((v == 2'd1) ? W : 1);
    chk("R2 phy clk", t_phy, 1);
    chk("R2 bus clk", t_bus, 2);
    chk("R2 core clk", t_core, 3);
    chk("R3 pd lift", t_pd, 4);
    if (v == 2'd2) chk("R4 ref no gap", t_ref, e_ref);
    else           chk("R3 ref after gap", t_ref, e_ref);
    if (en) chk("R5 ep release", t_ep, e_rel);
    else    chk("R6 ep release skip", t_ep, e_rel);
    chk("R5 ep released level", ep, !p);
    chk("R7 soft release", t_soft, (v == 2'd1) ? e_rel : 0);
    chk("R7 btn release", t_btn, (v == 2'd2) ? e_rel : 0);
    chk("R8 ready time", t_rdy, e_rdy);
    chk("R8 ready held", rdy, 1);
    if (disturb) chk("R10 stray start ignored", t_rdy, e_rdy);
    var_sel = v; ext_en = en;
  endtask

  task automatic do_shutdown(input string req);
    @(negedge clk);
    shut = 1'b1; start = 1'b1;
    @(negedge clk);
    chk_reset_state(req);
    @(negedge clk);
    chk({req, " start blocked"}, phyc, 0);
    shut = 1'b0; start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_reset_state("R1 reset");
  endtask

  task automatic t_variants;
    run_seq(2'd0, 1'b1, 1'b1, 1'b0); do_shutdown("R9 from done basic");
    run_seq(2'd1, 1'b1, 1'b0, 1'b0); do_shutdown("R9 from done soft");
    run_seq(2'd2, 1'b1, 1'b1, 1'b0); do_shutdown("R9 from done btn");
    run_seq(2'd3, 1'b0, 1'b0, 1'b0); do_shutdown("R9 from done alt");
    run_seq(2'd1, 1'b0, 1'b1, 1'b0); do_shutdown("R9 from done noext");
  endtask

  task automatic t_disturb;
    run_seq(2'd0, 1'b1, 1'b1, 1'b1);
    @(negedge clk); start = 1'b1; var_sel = 2'd1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 start after ready", rdy, 1);
    chk("R10 soft kept", softr, 1);
    do_shutdown("R9 after disturb");
  endtask

  task automatic t_mid_shutdown;
    @(negedge clk);
    var_sel = 2'd1; ext_en = 1'b1; pol = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (8) @(negedge clk);
    chk("R9 mid-run ref on", refc, 1);
    do_shutdown("R9 mid-run");
    run_seq(2'd1, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_variants;
    t_disturb;
    t_mid_shutdown;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule